// File: doc/BRIEF.md
# Register-Mapped SPI Master Port

This block is a synchronous serial port that acts as an SPI master behind a small bank of 32-bit registers. Software writes a byte to the transmit holding register. The port moves that byte into a shifter and clocks it out MSB first on `mosi`. In the same eight clock periods it captures eight bits from `miso` into the receive holding register. The serial clock rate, the clock polarity, the sampling phase and an internal loopback are all set through registers. Chip select is not part of the block: general-purpose pins outside the port drive it.

Status has three flags: receive ready, transmit ready and overrun. An interrupt mask selects which of them raise the level interrupt. Software sets mask bits through one register and clears them through another, so a read-modify-write is never needed. The command register takes write-only pulses. They reset, enable or disable the receiver and the transmitter separately.

The register port is a plain single-cycle interface. A write takes effect on the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr`. A read of the receive holding register consumes the byte on the edge where `bus_rd` is high.

Top module: `spi_regport`

## Requirements
- R1: After reset the status word at 0x14 reads 0x00000002, with only transmit ready set. The mask at 0x10 reads 0, `irq` is 0, `sclk` and `mosi` are 0, the divider at 0x20 reads 6, and 0xFC returns the VERSION parameter.
- R2: The mode register at 0x04 keeps only bits 3:0, 7:6, 8, 15 and 16; every other bit reads back as 0. No frame starts unless bits 3:0 equal 0xE (master). Bit 8 selects the phase, bit 15 selects loopback and bit 16 selects the polarity.
- R3: In the command register at 0x00, bit 4 enables the receiver, bit 5 disables it, bit 6 enables the transmitter and bit 7 disables it. When the enable and disable bits for one direction are written together, disable wins.
- R4: Each frame is 8 bits, full duplex, MSB first. With phase 0, `miso` is sampled on the leading `sclk` edge and `mosi` changes on the trailing edge. With phase 1, `mosi` changes on the leading edge and `miso` is sampled on the trailing edge. The captured byte appears at 0x18.
- R5: With loopback set, the received byte equals the transmitted byte whatever `miso` carries.
- R6: One `sclk` period is the effective divider in clock cycles. The effective divider is the value at 0x20, raised to 6 if below 6 and lowered to 65536 if above 65536. Between frames `sclk` rests at the polarity bit.
- R7: Transmit ready (status bit 1) clears on a write to 0x1C. It sets again when the byte moves into the shifter. A byte written while a frame is running waits for the next frame.
- R8: Receive ready (status bit 0) sets when a frame ends with the receiver enabled. A read of 0x18 clears it. With the receiver disabled, a finished frame is discarded and the flag is untouched.
- R9: Overrun (status bit 5) sets when a frame ends while receive ready is still set. The newer byte replaces the older one. A receiver reset (command bit 2) clears both receive ready and overrun.
- R10: A transmitter reset (command bit 3) stops the running frame without producing a received byte. It drops any pending byte, sets transmit ready and returns `sclk` to the polarity level.
- R11: Writing 1s to 0x08 sets mask bits and writing 1s to 0x0C clears them. Only bits 0, 1 and 5 exist. `irq` is high while any status bit and its mask bit are both 1.
- R12: Unmapped offsets read 0. Writes to the read-only offsets (0x10, 0x14, 0x18, 0xFC) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (consumes receive data) |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Level interrupt from masked status |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Stuck or misordered shift state shows at the ports within one frame, as a wrong byte in the receive holding register or a wrong bit sequence on `mosi`. A byte-level slave model on the bench sees the difference. A divider fault shows as a measured leading-edge spacing that differs from the effective divider, visible after the second leading edge. Flag faults in the holding logic show on the next read of the status word or as a wrong `irq` level. An aborted frame that leaks through would show as a spurious receive ready some hundreds of cycles after the transmitter reset.

// File: rtl/spu_pkg.sv
package spu_pkg;

    localparam int REG_AW = 8;

    localparam logic [REG_AW-1:0] OFF_CMD  = 8'h00;
    localparam logic [REG_AW-1:0] OFF_MODE = 8'h04;
    localparam logic [REG_AW-1:0] OFF_IEN  = 8'h08;
    localparam logic [REG_AW-1:0] OFF_IDIS = 8'h0C;
    localparam logic [REG_AW-1:0] OFF_MASK = 8'h10;
    localparam logic [REG_AW-1:0] OFF_STAT = 8'h14;
    localparam logic [REG_AW-1:0] OFF_RHR  = 8'h18;
    localparam logic [REG_AW-1:0] OFF_THR  = 8'h1C;
    localparam logic [REG_AW-1:0] OFF_DIV  = 8'h20;
    localparam logic [REG_AW-1:0] OFF_VER  = 8'hFC;

    // command pulse bit positions
    localparam int CMD_RX_RST = 2;
    localparam int CMD_TX_RST = 3;
    localparam int CMD_RX_ON  = 4;
    localparam int CMD_RX_OFF = 5;
    localparam int CMD_TX_ON  = 6;
    localparam int CMD_TX_OFF = 7;

    // status / mask flag positions
    localparam int FL_RX  = 0;
    localparam int FL_TX  = 1;
    localparam int FL_OVR = 5;
    localparam logic [31:0] FLAG_BITS = 32'h0000_0023;

    // mode register fields
    localparam int MD_PHASE = 8;
    localparam int MD_LOOP  = 15;
    localparam int MD_POL   = 16;
    localparam logic [3:0]  MD_MASTER = 4'hE;
    localparam logic [31:0] MODE_BITS = 32'h0001_81CF;

    typedef struct packed {
        logic master;
        logic pol;
        logic phase;
        logic loop;
    } lane_cfg_t;

endpackage

// File: rtl/spu_regfile.sv
module spu_regfile
    import spu_pkg::*;
#(
    parameter int          DIV_W   = 17,
    parameter int          DIV_RST = 6,
    parameter int          FRAME_W = 8,
    parameter logic [31:0] VERSION = 32'h0001_0200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rx_rdy,
    input  logic              tx_rdy,
    input  logic              ovr,
    input  logic [FRAME_W-1:0] rhr,
    output lane_cfg_t         cfg,
    output logic [DIV_W-1:0]  div_raw,
    output logic              rx_en,
    output logic              tx_en,
    output logic              rx_rst,
    output logic              tx_rst,
    output logic              thr_wr,
    output logic              rhr_rd,
    output logic              irq
);

    typedef struct packed {
        logic [31:0]      mode;
        logic [31:0]      mask;
        logic [DIV_W-1:0] div;
        logic             rx_en;
        logic             tx_en;
    } rf_t;

    rf_t         s_d, s_q;
    logic [31:0] stat_word;

    always_comb begin
        stat_word         = '0;
        stat_word[FL_RX]  = rx_rdy;
        stat_word[FL_TX]  = tx_rdy;
        stat_word[FL_OVR] = ovr;

        s_d = s_q;
        if (bus_wr) begin
            case (bus_addr)
                OFF_CMD: begin
                    if (bus_wdata[CMD_RX_ON])  s_d.rx_en = 1'b1;
                    if (bus_wdata[CMD_RX_OFF]) s_d.rx_en = 1'b0;
                    if (bus_wdata[CMD_TX_ON])  s_d.tx_en = 1'b1;
                    if (bus_wdata[CMD_TX_OFF]) s_d.tx_en = 1'b0;
                end
                OFF_MODE: s_d.mode = bus_wdata & MODE_BITS;
                OFF_IEN:  s_d.mask = s_q.mask | (bus_wdata & FLAG_BITS);
                OFF_IDIS: s_d.mask = s_q.mask & ~bus_wdata;
                OFF_DIV:  s_d.div  = bus_wdata[DIV_W-1:0];
                default: ;
            endcase
        end

        case (bus_addr)
            OFF_MODE: bus_rdata = s_q.mode;
            OFF_MASK: bus_rdata = s_q.mask;
            OFF_STAT: bus_rdata = stat_word;
            OFF_RHR:  bus_rdata = {{(32-FRAME_W){1'b0}}, rhr};
            OFF_DIV:  bus_rdata = {{(32-DIV_W){1'b0}}, s_q.div};
            OFF_VER:  bus_rdata = VERSION;
            default:  bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mode  <= '0;
            s_q.mask  <= '0;
            s_q.div   <= DIV_W'(DIV_RST);
            s_q.rx_en <= 1'b0;
            s_q.tx_en <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rx_rst     = bus_wr && (bus_addr == OFF_CMD) && bus_wdata[CMD_RX_RST];
    assign tx_rst     = bus_wr && (bus_addr == OFF_CMD) && bus_wdata[CMD_TX_RST];
    assign thr_wr     = bus_wr && (bus_addr == OFF_THR);
    assign rhr_rd     = bus_rd && (bus_addr == OFF_RHR);
    assign cfg.master = (s_q.mode[3:0] == MD_MASTER);
    assign cfg.pol    = s_q.mode[MD_POL];
    assign cfg.phase  = s_q.mode[MD_PHASE];
    assign cfg.loop   = s_q.mode[MD_LOOP];
    assign div_raw    = s_q.div;
    assign rx_en      = s_q.rx_en;
    assign tx_en      = s_q.tx_en;
    assign irq        = |(stat_word & s_q.mask);

    p_ien_sets_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_IEN) |=>
        ((s_q.mask & $past(bus_wdata & FLAG_BITS)) == $past(bus_wdata & FLAG_BITS)));

    p_idis_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_IDIS) |=> ((s_q.mask & $past(bus_wdata)) == 32'h0));

    p_rx_off_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_CMD && bus_wdata[CMD_RX_OFF]) |=> !s_q.rx_en);

    p_tx_off_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_CMD && bus_wdata[CMD_TX_OFF]) |=> !s_q.tx_en);

endmodule

// File: rtl/spu_baud.sv
module spu_baud #(
    parameter int DIV_W   = 17,
    parameter int DIV_MIN = 6,
    parameter int DIV_MAX = 65536
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_raw,
    output logic             lead,
    output logic             trail
);

    localparam logic [DIV_W-1:0] LO = DIV_W'(DIV_MIN);
    localparam logic [DIV_W-1:0] HI = DIV_W'(DIV_MAX);

    logic [DIV_W-1:0] eff, half;
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (div_raw < LO)      eff = LO;
        else if (div_raw > HI) eff = HI;
        else                   eff = div_raw;
        half  = eff >> 1;
        lead  = run && (cnt_q == half - 1'b1);
        trail = run && (cnt_q >= eff - 1'b1);
        if (!run || trail) cnt_d = '0;
        else               cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    p_edges_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead && trail));

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/spu_shifter.sv
module spu_shifter #(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] start_data,
    input  logic               cpol,
    input  logic               cpha,
    input  logic               loop,
    input  logic               miso,
    input  logic               lead,
    input  logic               trail,
    input  logic               abort,
    output logic               busy,
    output logic               done,
    output logic [FRAME_W-1:0] rx_byte,
    output logic               sclk,
    output logic               mosi
);

    localparam int BIT_W = $clog2(FRAME_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

    typedef struct packed {
        logic               busy;
        logic               done;
        logic               sclk;
        logic               mosi;
        logic [FRAME_W-1:0] tx_sh;
        logic [FRAME_W-1:0] rx_sh;
        logic [BIT_W-1:0]   bit_cnt;
    } sh_t;

    sh_t  s_d, s_q;
    logic din;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        din      = loop ? s_q.mosi : miso;

        if (abort) begin
            s_d.busy = 1'b0;
            s_d.sclk = cpol;
        end else if (!s_q.busy) begin
            s_d.sclk = cpol;
            if (start) begin
                s_d.busy    = 1'b1;
                s_d.bit_cnt = '0;
                if (!cpha) begin
                    s_d.mosi  = start_data[FRAME_W-1];
                    s_d.tx_sh = {start_data[FRAME_W-2:0], 1'b0};
                end else begin
                    s_d.tx_sh = start_data;
                end
            end
        end else if (lead) begin
            s_d.sclk = ~s_q.sclk;
            if (!cpha) begin
                s_d.rx_sh = {s_q.rx_sh[FRAME_W-2:0], din};
            end else begin
                s_d.mosi  = s_q.tx_sh[FRAME_W-1];
                s_d.tx_sh = {s_q.tx_sh[FRAME_W-2:0], 1'b0};
            end
        end else if (trail) begin
            s_d.sclk = ~s_q.sclk;
            if (!cpha) begin
                s_d.mosi  = s_q.tx_sh[FRAME_W-1];
                s_d.tx_sh = {s_q.tx_sh[FRAME_W-2:0], 1'b0};
            end else begin
                s_d.rx_sh = {s_q.rx_sh[FRAME_W-2:0], din};
            end
            if (s_q.bit_cnt == LAST_BIT) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end else begin
                s_d.bit_cnt = s_q.bit_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy    = s_q.busy;
    assign done    = s_q.done;
    assign rx_byte = s_q.rx_sh;
    assign sclk    = s_q.sclk;
    assign mosi    = s_q.mosi;

    p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !lead && !trail && !abort) |=> $stable(s_q.mosi));

    p_idle_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!s_q.busy && s_q.sclk == $past(cpol) && !s_q.done));

    p_done_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> (!s_q.busy && s_q.sclk == $past(s_q.sclk) ^ 1'b1));

endmodule

// File: rtl/spu_buffers.sv
module spu_buffers #(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               thr_wr,
    input  logic [FRAME_W-1:0] wdata,
    input  logic               rhr_rd,
    input  logic               rx_rst,
    input  logic               tx_rst,
    input  logic               rx_en,
    input  logic               tx_en,
    input  logic               mode_ok,
    input  logic               busy,
    input  logic               done,
    input  logic [FRAME_W-1:0] rx_byte,
    output logic               start,
    output logic [FRAME_W-1:0] start_data,
    output logic [FRAME_W-1:0] rhr,
    output logic               rx_rdy,
    output logic               tx_rdy,
    output logic               ovr
);

    typedef struct packed {
        logic [FRAME_W-1:0] thr;
        logic               thr_full;
        logic [FRAME_W-1:0] rhr;
        logic               rx_rdy;
        logic               ovr;
    } buf_t;

    buf_t s_d, s_q;

    always_comb begin
        start = s_q.thr_full && tx_en && mode_ok && !busy && !tx_rst;
        s_d   = s_q;

        if (start)  s_d.thr_full = 1'b0;
        if (thr_wr) begin
            s_d.thr      = wdata;
            s_d.thr_full = 1'b1;
        end
        if (tx_rst) s_d.thr_full = 1'b0;

        if (rhr_rd) s_d.rx_rdy = 1'b0;
        if (done && rx_en) begin
            s_d.rhr    = rx_byte;
            s_d.rx_rdy = 1'b1;
            if (s_q.rx_rdy && !rhr_rd) s_d.ovr = 1'b1;
        end
        if (rx_rst) begin
            s_d.rx_rdy = 1'b0;
            s_d.ovr    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign start_data = s_q.thr;
    assign rhr        = s_q.rhr;
    assign rx_rdy     = s_q.rx_rdy;
    assign tx_rdy     = !s_q.thr_full;
    assign ovr        = s_q.ovr;

    p_ovr_needs_unread_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.ovr) |-> $past(s_q.rx_rdy));

    p_rx_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rst |=> (!s_q.rx_rdy && !s_q.ovr));

    p_thr_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr && !tx_rst) |=> s_q.thr_full);

    p_tx_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rst |=> !s_q.thr_full);

endmodule

// File: rtl/spi_regport.sv
module spi_regport
    import spu_pkg::*;
#(
    parameter int          FRAME_W = 8,
    parameter int          DIV_W   = 17,
    parameter int          DIV_MIN = 6,
    parameter int          DIV_MAX = 65536,
    parameter logic [31:0] VERSION = 32'h0001_0200
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso
);

    lane_cfg_t          cfg;
    logic [DIV_W-1:0]   div_raw;
    logic               rx_en, tx_en, rx_rst, tx_rst, thr_wr, rhr_rd;
    logic               rx_rdy, tx_rdy, ovr;
    logic [FRAME_W-1:0] rhr, start_data, rx_byte;
    logic               start, busy, done, lead, trail;

    spu_regfile #(
        .DIV_W(DIV_W), .DIV_RST(DIV_MIN), .FRAME_W(FRAME_W), .VERSION(VERSION)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_rdy(rx_rdy), .tx_rdy(tx_rdy), .ovr(ovr), .rhr(rhr),
        .cfg(cfg), .div_raw(div_raw), .rx_en(rx_en), .tx_en(tx_en),
        .rx_rst(rx_rst), .tx_rst(tx_rst), .thr_wr(thr_wr), .rhr_rd(rhr_rd),
        .irq(irq)
    );

    spu_buffers #(.FRAME_W(FRAME_W)) u_bufs (
        .clk(clk), .rst_n(rst_n),
        .thr_wr(thr_wr), .wdata(bus_wdata[FRAME_W-1:0]), .rhr_rd(rhr_rd),
        .rx_rst(rx_rst), .tx_rst(tx_rst), .rx_en(rx_en), .tx_en(tx_en),
        .mode_ok(cfg.master), .busy(busy), .done(done), .rx_byte(rx_byte),
        .start(start), .start_data(start_data), .rhr(rhr),
        .rx_rdy(rx_rdy), .tx_rdy(tx_rdy), .ovr(ovr)
    );

    spu_baud #(.DIV_W(DIV_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(busy && !tx_rst), .div_raw(div_raw),
        .lead(lead), .trail(trail)
    );

    spu_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .start(start), .start_data(start_data),
        .cpol(cfg.pol), .cpha(cfg.phase), .loop(cfg.loop), .miso(miso),
        .lead(lead), .trail(trail), .abort(tx_rst),
        .busy(busy), .done(done), .rx_byte(rx_byte),
        .sclk(sclk), .mosi(mosi)
    );

endmodule

// File: tb/spi_regport_test.sv
module spi_regport_test;

    localparam logic [31:0] VER = 32'h0001_0200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq, sclk, mosi, miso;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // bench-side slave model state
    logic [7:0] slave_byte = 8'h00;
    logic       b_cpha = 1'b0;
    logic       mon_clr = 1'b0;
    logic       sclk_prev = 1'b0;
    logic [7:0] mon_sh = 8'h00;
    logic [7:0] mon_byte = 8'h00;
    int         edge_k = 0;
    int         bit_i = 0;
    int         last_lead = 0;
    int         mon_period = 0;
    int         nlead = 0;
    int         mon_edges = 0;

    spi_regport #(.VERSION(VER)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    assign miso = (bit_i < 8) ? slave_byte[7 - bit_i] : 1'b0;

    always @(negedge clk) begin
        if (mon_clr) begin
            edge_k = 0; bit_i = 0; nlead = 0; mon_edges = 0; mon_period = 0;
        end else if (rst_n && sclk !== sclk_prev) begin
            mon_edges = mon_edges + 1;
            if (edge_k % 2 == 0) begin
                if (nlead > 0) mon_period = cyc - last_lead;
                last_lead = cyc;
                nlead = nlead + 1;
            end
            if (((edge_k % 2) == 0) != b_cpha) begin
                mon_sh = {mon_sh[6:0], mosi};
                bit_i = bit_i + 1;
            end
            edge_k = edge_k + 1;
            if (edge_k == 16) begin
                edge_k = 0;
                bit_i = 0;
                mon_byte = mon_sh;
            end
        end
        sclk_prev = sclk;
    end

    function automatic int eff_div(input int w);
        if (w < 6) return 6;
        if (w > 65536) return 65536;
        return w;
    endfunction

    function automatic logic [7:0] exp_rx(input logic lp, input logic [7:0] t, input logic [7:0] s);
        return lp ? t : s;
    endfunction

    function automatic logic [31:0] mode_word(input logic p, input logic h, input logic l);
        return 32'h0000_00CE | (32'(h) << 8) | (32'(l) << 15) | (32'(p) << 16);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #2;
        d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic mon_clear();
        @(posedge clk);
        mon_clr = 1'b1;
        @(posedge clk);
        mon_clr = 1'b0;
    endtask

    task automatic set_mode(input logic p, input logic h, input logic l);
        b_cpha = h;
        wr(8'h04, mode_word(p, h, l));
        repeat (2) @(negedge clk);
        mon_clear();
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic frame_rand();
        logic [7:0] t, s;
        logic p, h, l;
        int d;
        logic [31:0] v;
        t = 8'($urandom); s = 8'($urandom);
        p = 1'($urandom); h = 1'($urandom); l = 1'($urandom);
        d = 6 + int'($urandom % 7);
        set_mode(p, h, l);
        wr(8'h20, 32'(d));
        slave_byte = s;
        wr(8'h1C, {24'h0, t});
        repeat (8 * d + 16) @(negedge clk);
        rd(8'h18, v);
        chk(l ? "R5 loopback byte" : "R4 received byte", v, {24'h0, exp_rx(l, t, s)});
        chk("R4 mosi bit order", {24'h0, mon_byte}, {24'h0, t});
        chk("R6 sclk period", 32'(mon_period), 32'(eff_div(d)));
        chk("R6 sclk idle level", {31'h0, sclk}, {31'h0, p});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        summary();
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        rd(8'h14, v); chk("R1 status after reset", v, 32'h2);
        rd(8'h10, v); chk("R1 mask after reset", v, 32'h0);
        rd(8'h20, v); chk("R1 divider after reset", v, 32'd6);
        rd(8'hFC, v); chk("R1 version", v, VER);
        chk("R1 irq/sclk/mosi idle", {29'h0, irq, sclk, mosi}, 32'h0);

        // R12 unmapped and read-only
        rd(8'h24, v); chk("R12 unmapped reads zero", v, 32'h0);
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'hFC, 32'h0);
        rd(8'h14, v); chk("R12 status write ignored", v, 32'h2);
        rd(8'hFC, v); chk("R12 version write ignored", v, VER);

        // R2 mode readback keeps only defined bits
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, v); chk("R2 mode readback mask", v, 32'h0001_81CF);

        // R2 no frame without master field
        wr(8'h04, 32'h0000_00C0);
        repeat (2) @(negedge clk);
        mon_clear();
        wr(8'h00, 32'h50);
        wr(8'h1C, 32'h5A);
        repeat (80) @(negedge clk);
        rd(8'h14, v); chk("R2 no load without master", v & 32'h2, 32'h0);
        chk("R2 no sclk toggles", 32'(mon_edges), 32'h0);
        wr(8'h00, 32'h08);

        // R4 directed frame, mode 0
        set_mode(1'b0, 1'b0, 1'b0);
        slave_byte = 8'h3C;
        wr(8'h1C, 32'hA5);
        repeat (8 * 6 + 16) @(negedge clk);
        rd(8'h14, v); chk("R8 receive ready set", v & 32'h1, 32'h1);
        rd(8'h18, v); chk("R4 directed received byte", v, 32'h3C);
        chk("R4 directed mosi byte", {24'h0, mon_byte}, 32'hA5);
        rd(8'h14, v); chk("R8 read clears receive ready", v & 32'h1, 32'h0);

        // R5 directed loopback, phase 1
        set_mode(1'b1, 1'b1, 1'b1);
        slave_byte = 8'h00;
        wr(8'h1C, 32'h96);
        repeat (8 * 6 + 16) @(negedge clk);
        rd(8'h18, v); chk("R5 loopback ignores miso", v, 32'h96);

        // R6 low clamp
        set_mode(1'b0, 1'b0, 1'b0);
        wr(8'h20, 32'd2);
        rd(8'h20, v); chk("R6 divider raw readback", v, 32'd2);
        wr(8'h1C, 32'h0F);
        repeat (8 * 6 + 16) @(negedge clk);
        chk("R6 clamp to minimum", 32'(mon_period), 32'd6);
        rd(8'h18, v);
        wr(8'h20, 32'd6);

        // random frames
        for (int i = 0; i < 24; i++) frame_rand();

        // R7 transmit ready with transmitter disabled then enabled
        set_mode(1'b0, 1'b0, 1'b0);
        wr(8'h20, 32'd6);
        wr(8'h00, 32'h80);
        wr(8'h1C, 32'h11);
        rd(8'h14, v); chk("R7 write clears transmit ready", v & 32'h2, 32'h0);
        repeat (20) @(negedge clk);
        rd(8'h14, v); chk("R7 byte held while disabled", v & 32'h2, 32'h0);
        wr(8'h00, 32'h40);
        repeat (2) @(negedge clk);
        rd(8'h14, v); chk("R7 ready after load", v & 32'h2, 32'h2);
        repeat (8 * 6 + 16) @(negedge clk);
        rd(8'h18, v);

        // R7/R9 back-to-back bytes and overrun, loopback
        set_mode(1'b0, 1'b0, 1'b1);
        wr(8'h1C, 32'h21);
        wr(8'h1C, 32'h42);
        rd(8'h14, v); chk("R7 second byte waits", v & 32'h2, 32'h0);
        repeat (2 * 8 * 6 + 30) @(negedge clk);
        rd(8'h14, v); chk("R9 overrun flagged", v, 32'h23);

        // R11 mask and irq
        wr(8'h08, 32'h20);
        @(negedge clk);
        chk("R11 irq from overrun", {31'h0, irq}, 32'h1);
        rd(8'h10, v); chk("R11 mask set", v, 32'h20);
        wr(8'h0C, 32'h20);
        @(negedge clk);
        chk("R11 irq cleared with mask", {31'h0, irq}, 32'h0);
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h10, v); chk("R11 only defined mask bits", v, 32'h23);
        wr(8'h0C, 32'hFFFF_FFFF);

        rd(8'h18, v); chk("R9 newer byte kept", v, 32'h42);
        rd(8'h14, v); chk("R9 overrun sticky after read", v, 32'h22);
        wr(8'h00, 32'h04);
        rd(8'h14, v); chk("R9 receiver reset clears", v, 32'h02);

        // R8 receiver disabled discards
        set_mode(1'b0, 1'b0, 1'b0);
        wr(8'h00, 32'h20);
        wr(8'h1C, 32'h77);
        repeat (8 * 6 + 16) @(negedge clk);
        rd(8'h14, v); chk("R8 disabled receiver discards", v & 32'h1, 32'h0);

        // R3 disable wins for both directions
        wr(8'h00, 32'h30);
        wr(8'h1C, 32'h78);
        repeat (8 * 6 + 16) @(negedge clk);
        rd(8'h14, v); chk("R3 rx disable wins", v & 32'h1, 32'h0);
        wr(8'h00, 32'h10);
        wr(8'h00, 32'hC0);
        wr(8'h1C, 32'h79);
        repeat (20) @(negedge clk);
        rd(8'h14, v); chk("R3 tx disable wins", v & 32'h2, 32'h0);
        wr(8'h00, 32'h08);
        rd(8'h14, v); chk("R10 reset drops pending byte", v & 32'h2, 32'h2);
        wr(8'h00, 32'h40);
        repeat (8 * 6 + 16) @(negedge clk);
        rd(8'h14, v); chk("R10 dropped byte never sent", v & 32'h1, 32'h0);

        // R10 abort mid-frame, polarity 1
        set_mode(1'b1, 1'b0, 1'b0);
        wr(8'h1C, 32'hC3);
        repeat (20) @(negedge clk);
        wr(8'h00, 32'h08);
        chk("R10 sclk back to idle", {31'h0, sclk}, 32'h1);
        rd(8'h14, v); chk("R10 transmit ready after abort", v & 32'h3, 32'h2);
        repeat (100) @(negedge clk);
        rd(8'h14, v); chk("R10 aborted frame gives no byte", v & 32'h1, 32'h0);

        // R6 high clamp
        set_mode(1'b0, 1'b0, 1'b0);
        wr(8'h20, 32'h0001_FFFF);
        wr(8'h1C, 32'hE1);
        while (nlead < 2) @(posedge clk);
        @(negedge clk);
        chk("R6 clamp to maximum", 32'(mon_period), 32'd65536);
        wr(8'h00, 32'h08);
        wr(8'h20, 32'd6);

        summary();
    end

endmodule